// File: doc/BRIEF.md
# Priority to Preemption Class Mapper

This block decides, for each of eight transmit priorities, whether frames of that priority use the express path or the preemptable path. Software supplies a requested 8-bit class mask. The block also takes a flag that says the link partner has confirmed preemption support, and a per-priority indication that the transmit queue holds no frames. From these it keeps a registered class assignment that the transmit scheduler reads.

A requested change for a priority is committed only while that priority's queue is empty, so a frame never changes path while it waits. Each priority commits on its own. Until preemption is confirmed, every priority is steered to express, and that move is also gated by the queue draining. A per-priority pending flag shows when a requested change is held back by a busy queue.

Top module: `prio_class_mapper`

## Requirements
- R1: Bit i of `class_map` is the class of priority i (bit 0 is priority 0): 1 means preemptable, 0 means express.
- R2: With `verified` high and `queue_empty[i]` high at a rising edge, `class_map[i]` equals `req_mask[i]` after that edge.
- R3: With `queue_empty[i]` low at a rising edge, `class_map[i]` keeps its value across that edge, whatever `req_mask` and `verified` are.
- R4: With `verified` low and `queue_empty[i]` high at a rising edge, `class_map[i]` is 0 (express) after that edge.
- R5: After a rising edge, `pend[i]` is 1 exactly when, at that edge, the target class of priority i (`req_mask[i]` if `verified`, else 0) differed from `class_map[i]` and `queue_empty[i]` was low.
- R6: A synchronous active-high `rst` clears `class_map` and `pend` to all zeros.
- R7: Each priority commits independently: a busy queue on one priority does not hold back the change of another priority whose queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_mask | input | 8 | Requested class per priority, 1 = preemptable |
| verified | input | 1 | Preemption support confirmed with the link partner |
| queue_empty | input | 8 | Per-priority transmit queue holds no frames |
| class_map | output | 8 | Applied class per priority, registered |
| pend | output | 8 | Per-priority change waiting for its queue to drain, registered |

## Verification
Both `class_map` and `pend` are single registers fed from the inputs, so each result is due one rising edge after the inputs that caused it. The bench drives every input on the falling edge, lets exactly one rising edge pass, and compares both outputs against its own model on the next falling edge, before new inputs go in. Random masks, verify changes and queue states are mixed with directed cases for a held queue, a drop of verification, and one busy priority beside drained ones.

// File: rtl/prio_map_pkg.sv
package prio_map_pkg;
  localparam int unsigned NUM_PRIO_DEF = 8;

  typedef enum logic {
    CLASS_EXPRESS = 1'b0,
    CLASS_PREEMPT = 1'b1
  } class_e;
endpackage

// File: rtl/class_target_gen.sv
module class_target_gen #(
  parameter int unsigned NUM_PRIO = 8
) (
  input  logic [NUM_PRIO-1:0] req_mask,
  input  logic                verified,
  output logic [NUM_PRIO-1:0] target
);
  // Without confirmed preemption every priority aims at express.
  always_comb begin
    for (int i = 0; i < NUM_PRIO; i++) begin
      target[i] = verified ? req_mask[i] : prio_map_pkg::CLASS_EXPRESS;
    end
  end
endmodule

// File: rtl/prio_lane_cell.sv
module prio_lane_cell (
  input  logic clk,
  input  logic rst,
  input  logic target,
  input  logic empty,
  output logic applied,
  output logic waiting
);
  logic differs;
  logic commit;

  assign differs = (target != applied);
  assign commit  = differs && empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      applied <= 1'b0;
      waiting <= 1'b0;
    end else begin
      if (commit) begin
        applied <= target;
      end
      waiting <= differs && !empty;
    end
  end
endmodule

// File: rtl/prio_class_mapper.sv
module prio_class_mapper #(
  parameter int unsigned NUM_PRIO = prio_map_pkg::NUM_PRIO_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PRIO-1:0] req_mask,
  input  logic                verified,
  input  logic [NUM_PRIO-1:0] queue_empty,
  output logic [NUM_PRIO-1:0] class_map,
  output logic [NUM_PRIO-1:0] pend
);
  logic [NUM_PRIO-1:0] target;

  class_target_gen #(.NUM_PRIO(NUM_PRIO)) u_tgt (
    .req_mask (req_mask),
    .verified (verified),
    .target   (target)
  );

  for (genvar g = 0; g < NUM_PRIO; g++) begin : g_lane
    prio_lane_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .target  (target[g]),
      .empty   (queue_empty[g]),
      .applied (class_map[g]),
      .waiting (pend[g])
    );
  end
endmodule

// File: rtl/prio_class_mapper_chk.sv
module prio_class_mapper_chk #(
  parameter int unsigned NUM_PRIO = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PRIO-1:0] req_mask,
  input logic                verified,
  input logic [NUM_PRIO-1:0] queue_empty,
  input logic [NUM_PRIO-1:0] class_map,
  input logic [NUM_PRIO-1:0] pend
);
  // R6: reset clears both registered outputs
  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> (class_map == '0) && (pend == '0));

  for (genvar g = 0; g < NUM_PRIO; g++) begin : g_chk
    // R3: a busy queue freezes its class
    a_r3_hold_busy: assert property (@(posedge clk) disable iff (rst)
      !queue_empty[g] |=> $stable(class_map[g]));

    // R2: verified and drained follows the request
    a_r2_follow_req: assert property (@(posedge clk) disable iff (rst)
      (verified && queue_empty[g]) |=> class_map[g] == $past(req_mask[g]));

    // R4: not verified and drained goes express
    a_r4_express_unverified: assert property (@(posedge clk) disable iff (rst)
      (!verified && queue_empty[g]) |=> !class_map[g]);

    // R5: pending shows a blocked change
    a_r5_pending_flag: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> pend[g] == ($past(!queue_empty[g]) &&
        ($past(verified && req_mask[g]) != $past(class_map[g]))));
  end
endmodule

bind prio_class_mapper prio_class_mapper_chk #(.NUM_PRIO(NUM_PRIO)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_mask    (req_mask),
  .verified    (verified),
  .queue_empty (queue_empty),
  .class_map   (class_map),
  .pend        (pend)
);

// File: tb/sim_prio_class_mapper.sv
module sim_prio_class_mapper;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] req_mask;
  logic         verified;
  logic [N-1:0] queue_empty;
  logic [N-1:0] class_map;
  logic [N-1:0] pend;

  int total = 0;
  int bad   = 0;
  logic [N-1:0] exp_map = '0;
  logic [N-1:0] exp_pend = '0;

  always #10 clk = ~clk;

  prio_class_mapper #(.NUM_PRIO(N)) u0 (
    .clk(clk), .rst(rst), .req_mask(req_mask), .verified(verified),
    .queue_empty(queue_empty), .class_map(class_map), .pend(pend)
  );

  function automatic logic [N-1:0] want_map(input logic [N-1:0] cur,
      input logic [N-1:0] rq, input logic vf, input logic [N-1:0] em);
    logic [N-1:0] r = cur;
    for (int i = 0; i < N; i++)
      if (em[i]) r[i] = vf ? rq[i] : 1'b0;
    return r;
  endfunction

  function automatic logic [N-1:0] want_pend(input logic [N-1:0] cur,
      input logic [N-1:0] rq, input logic vf, input logic [N-1:0] em);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = !em[i] && ((vf ? rq[i] : 1'b0) != cur[i]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive at negedge, one rising edge, compare at next negedge.
  task automatic step(input logic [N-1:0] rq, input logic vf, input logic [N-1:0] em,
                      input string tag);
    req_mask = rq; verified = vf; queue_empty = em;
    exp_pend = want_pend(exp_map, rq, vf, em);
    exp_map  = want_map(exp_map, rq, vf, em);
    @(negedge clk);
    chk({tag, " class_map"}, class_map, exp_map);
    chk("R5 pend", pend, exp_pend);
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; req_mask = '1; verified = 1'b1; queue_empty = '1;
    @(negedge clk); @(negedge clk);
    chk("R6 reset class_map", class_map, '0);
    chk("R6 reset pend", pend, '0);
    rst = 1'b0;

    // R1: priority 5 alone goes preemptable at bit 5
    step(8'b0010_0000, 1'b1, '1, "R1");
    // R2: full request, all queues empty
    step(8'hA5, 1'b1, '1, "R2");
    // R3: all busy, new request held, pending raised
    step(8'h5A, 1'b1, '0, "R3");
    step(8'h5A, 1'b1, '0, "R3");
    // R7: only priority 0 drains, others keep waiting
    step(8'h5A, 1'b1, 8'h01, "R7");
    step(8'h5A, 1'b1, 8'hFE, "R7");
    // R4: verification lost, busy priority 2 stays, others go express
    step(8'hFF, 1'b0, 8'hFB, "R4");
    step(8'hFF, 1'b0, 8'hFF, "R4");

    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] rq = N'($urandom);
      logic vf = ($urandom % 8) != 0;
      logic [N-1:0] em = N'($urandom) | N'($urandom);
      step(rq, vf, em, vf ? "R2/R3/R7" : "R4/R3");
    end

    // R6: mid-run reset
    rst = 1'b1; req_mask = '1; verified = 1'b1; queue_empty = '0;
    @(negedge clk);
    exp_map = '0; exp_pend = '0;
    chk("R6 reset class_map", class_map, '0);
    chk("R6 reset pend", pend, '0);
    rst = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule